// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes one asynchronous serial line and turns it back into 8-bit characters. The line rests at logic 1. A character begins with a single start bit at logic 0. Eight data bits follow, then a stop bit at logic 1. Nothing marks where a character ends: the receiver knows the end only because it knows the bit count and the bit rate.

The line input first passes through a two-flop synchroniser. A free-running divider then produces an oversampling tick, by default sixteen ticks per bit period. The receiver detects the fall from the rest level to the start level and confirms the start bit at its midpoint. It then samples every later bit at the centre of its period.

Each finished character is presented on the data bus with a one-cycle valid strobe. A framing-error flag accompanies the strobe when the stop bit reads 0. A mode input selects the order in which data bits arrive. The receiver accepts characters separated by a single stop bit with no extra fill.

Top module: `async_char_rx`

## Requirements
- R1: After reset `rx_valid`, `rx_ferr` and `rx_data` are all 0, and while the line stays at 1 no strobe is produced.
- R2: A character starts only on a 1-to-0 change of the line. A line that is held at 0 from reset onward produces no strobe until it has gone to 1 and fallen again.
- R3: The start bit is re-checked at its midpoint. A low pulse shorter than half a bit period produces no strobe, and the next real character is received correctly.
- R4: Exactly 8 data bits follow the start bit, each sampled at the centre of its period. With `lsb_first` = 0 the first data bit received becomes `rx_data[7]` and the last becomes `rx_data[0]`.
- R5: With `lsb_first` = 1 the first data bit received becomes `rx_data[0]` and the last becomes `rx_data[7]`. The mode is taken when the start bit is detected.
- R6: A stop bit read as 1 at its midpoint delivers the character with `rx_ferr` = 0.
- R7: A stop bit read as 0 delivers the character with `rx_ferr` = 1. `rx_ferr` is never high without `rx_valid`. After a framing error the receiver starts no new character until the line has returned to 1.
- R8: Characters sent back to back, with exactly one stop bit period between them, are all received in order.
- R9: `rx_valid` lasts exactly one clock cycle per character, and `rx_data` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial line, rests at 1 |
| lsb_first | input | 1 | Bit order: 0 = most significant bit first, 1 = least significant bit first |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| rx_data | output | 8 | Received character, held until the next strobe |
| rx_ferr | output | 1 | Framing error: the stop bit read 0; valid only with `rx_valid` |

## Verification
The bench builds the receiver with four clocks per tick and the default sixteen ticks per bit. A bit therefore lasts 64 clocks and a whole character 640 clocks. At that rate one run can cover every scenario: the line held low from reset, short glitches, both bit orders, framing errors with the line held low afterwards, and runs of back-to-back characters. The short tick period also keeps the phase uncertainty of the free-running divider a small share of the bit. That puts the midpoint timing of the start re-check and of the stop sample under test without any extra margin.

// File: rtl/async_char_rx_pkg.sv
package async_char_rx_pkg;

    localparam int CHAR_BITS = 8;
    localparam int IDX_W     = $clog2(CHAR_BITS);

    typedef enum logic [2:0] {
        RX_WAIT_HIGH = 3'd0,
        RX_IDLE      = 3'd1,
        RX_START     = 3'd2,
        RX_DATA      = 3'd3,
        RX_STOP      = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_BITS-1:0] data;
        logic                 ferr;
    } rx_result_t;

    // Insert one sampled bit into the assembly register for the chosen order.
    function automatic logic [CHAR_BITS-1:0] put_bit(
        input logic [CHAR_BITS-1:0] acc,
        input logic                 b,
        input logic                 lsb_order
    );
        if (lsb_order)
            return {b, acc[CHAR_BITS-1:1]};
        else
            return {acc[CHAR_BITS-2:0], b};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_async,
    output logic line_sync
);
    logic [STAGES-1:0] pipe;

    // Resets to 0 so that a line held low from reset never looks like rest level.
    always_ff @(posedge clk) begin
        if (rst)
            pipe <= '0;
        else
            pipe <= {pipe[STAGES-2:0], line_async};
    end

    assign line_sync = pipe[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int CLKS_PER_TICK = 68
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divider
            localparam int DW = $clog2(CLKS_PER_TICK);
            localparam logic [DW-1:0] LAST = DW'(CLKS_PER_TICK - 1);
            logic [DW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (rst)
                    div_q <= '0;
                else if (div_q == LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import async_char_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 lsb_first,
    output logic                 valid,
    output rx_result_t           result
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_BITS - 1);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [IDX_W-1:0]     idx;
    logic [CHAR_BITS-1:0] acc;
    logic                 order_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_WAIT_HIGH;
            cnt     <= '0;
            idx     <= '0;
            acc     <= '0;
            order_q <= 1'b0;
            valid   <= 1'b0;
            result  <= '0;
        end else begin
            valid       <= 1'b0;
            result.ferr <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_WAIT_HIGH: begin
                        if (line) state <= RX_IDLE;
                    end
                    RX_IDLE: begin
                        if (!line) begin
                            state   <= RX_START;
                            cnt     <= '0;
                            order_q <= lsb_first;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            if (line) begin
                                state <= RX_IDLE;
                            end else begin
                                state <= RX_DATA;
                                cnt   <= '0;
                                idx   <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            acc <= put_bit(acc, line, order_q);
                            cnt <= '0;
                            if (idx == LAST_IDX)
                                state <= RX_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST) begin
                            valid       <= 1'b1;
                            result.data <= acc;
                            result.ferr <= !line;
                            state       <= line ? RX_IDLE : RX_WAIT_HIGH;
                            cnt         <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_WAIT_HIGH;
                endcase
            end
        end
    end

    // R2
    start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && $past(state) != RX_START)
            |-> ($past(state) == RX_IDLE && !$past(line)));

    // R3
    glitch_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && $past(state) == RX_START) |-> $past(line));

    // R4
    bit_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_STOP && $past(state) != RX_STOP) |-> ($past(idx) == LAST_IDX));

    // R7
    ferr_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && result.ferr) |-> (state == RX_WAIT_HIGH));
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_char_rx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 68,
    parameter int OVERSAMPLE    = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic                 lsb_first,
    output logic                 rx_valid,
    output logic [CHAR_BITS-1:0] rx_data,
    output logic                 rx_ferr
);
    logic       line_s;
    logic       tick;
    rx_result_t res;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .line_async (rx_line),
        .line_sync  (line_s)
    );

    rx_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line      (line_s),
        .lsb_first (lsb_first),
        .valid     (rx_valid),
        .result    (res)
    );

    assign rx_data = res.data;
    assign rx_ferr = res.ferr;

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_data));

    // R7
    ferr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ferr |-> rx_valid);
endmodule

// File: tb/tb_async_char_rx.sv
module tb_async_char_rx;
    localparam int CPT = 4;
    localparam int OS  = 16;
    localparam int BIT = CPT * OS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b0;
    logic       lsb_sel = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ferr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int         cap_cnt = 0;
    logic [7:0] cap_data [0:15];
    logic       cap_ferr [0:15];
    logic       prev_valid = 1'b0;
    logic [7:0] prev_data  = 8'h00;
    int         pulse_bad = 0;
    int         hold_bad  = 0;

    always #4 clk = ~clk;

    async_char_rx #(.CLKS_PER_TICK(CPT), .OVERSAMPLE(OS)) dut (
        .clk       (clk),
        .rst       (rst),
        .rx_line   (rx_line),
        .lsb_first (lsb_sel),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ferr   (rx_ferr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                cap_data[cap_cnt % 16] = rx_data;
                cap_ferr[cap_cnt % 16] = rx_ferr;
                cap_cnt++;
            end
            if (rx_valid && prev_valid) pulse_bad++;
            if (!rx_valid && rx_data != prev_data) hold_bad++;
            prev_valid = rx_valid;
            prev_data  = rx_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [7:0] v, input logic lsb, input logic stop_lvl);
        rx_line = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = lsb ? v[i] : v[7 - i];
            repeat (BIT) @(negedge clk);
        end
        rx_line = stop_lvl;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic expect_char(input int base, input logic [7:0] v, input logic fe, input string req);
        check(cap_cnt == base + 1, {req, " count"}, cap_cnt, base + 1);
        check(cap_data[base % 16] == v, {req, " data"}, cap_data[base % 16], v);
        check(cap_ferr[base % 16] == fe, {req, " ferr"}, cap_ferr[base % 16], fe);
    endtask

    task automatic t_reset_and_held_low();
        int base;
        rx_line = 1'b0;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
        check(rx_data == 8'h00, "R1 data after reset", rx_data, 0);
        check(rx_ferr == 1'b0, "R1 ferr after reset", rx_ferr, 0);
        wait_bits(12);
        check(cap_cnt == 0, "R2 held low gives no char", cap_cnt, 0);
        rx_line = 1'b1;
        wait_bits(20);
        check(cap_cnt == 0, "R1 idle gives no char", cap_cnt, 0);
        base = cap_cnt;
        drive_frame(8'hA5, 1'b0, 1'b1);
        expect_char(base, 8'hA5, 1'b0, "R2 first edge");
    endtask

    task automatic t_msb_first();
        logic [7:0] vals [3] = '{8'h41, 8'h80, 8'h01};
        lsb_sel = 1'b0;
        foreach (vals[k]) begin
            int base = cap_cnt;
            drive_frame(vals[k], 1'b0, 1'b1);
            expect_char(base, vals[k], 1'b0, "R4 R6 msb order");
            wait_bits(2);
        end
    endtask

    task automatic t_lsb_first();
        logic [7:0] vals [3] = '{8'h01, 8'hC2, 8'h7E};
        lsb_sel = 1'b1;
        foreach (vals[k]) begin
            int base = cap_cnt;
            drive_frame(vals[k], 1'b1, 1'b1);
            expect_char(base, vals[k], 1'b0, "R5 lsb order");
            wait_bits(1);
        end
        lsb_sel = 1'b0;
    endtask

    task automatic t_glitch();
        int base = cap_cnt;
        rx_line = 1'b0;
        repeat (24) @(negedge clk);
        rx_line = 1'b1;
        wait_bits(3);
        check(cap_cnt == base, "R3 glitch gives no char", cap_cnt, base);
        drive_frame(8'h96, 1'b0, 1'b1);
        expect_char(base, 8'h96, 1'b0, "R3 after glitch");
        wait_bits(1);
    endtask

    task automatic t_framing();
        int base = cap_cnt;
        drive_frame(8'h3C, 1'b0, 1'b0);
        wait_bits(6);
        expect_char(base, 8'h3C, 1'b1, "R7 stop low");
        rx_line = 1'b1;
        wait_bits(1);
        check(cap_cnt == base + 1, "R7 no rearm while low", cap_cnt, base + 1);
        base = cap_cnt;
        drive_frame(8'h5A, 1'b0, 1'b1);
        expect_char(base, 8'h5A, 1'b0, "R7 rearm after high");
        wait_bits(1);
    endtask

    task automatic t_back_to_back();
        logic [7:0] vals [4] = '{8'h11, 8'h22, 8'hF0, 8'h0F};
        int base = cap_cnt;
        foreach (vals[k]) drive_frame(vals[k], 1'b0, 1'b1);
        check(cap_cnt == base + 4, "R8 b2b count", cap_cnt, base + 4);
        foreach (vals[k])
            check(cap_data[(base + k) % 16] == vals[k] && cap_ferr[(base + k) % 16] == 1'b0,
                  "R8 b2b data", cap_data[(base + k) % 16], vals[k]);
        wait_bits(2);
    endtask

    initial begin
        t_reset_and_held_low();
        t_msb_first();
        t_lsb_first();
        t_glitch();
        t_framing();
        t_back_to_back();
        check(pulse_bad == 0, "R9 strobe width", pulse_bad, 0);
        check(hold_bad == 0, "R9 data hold", hold_bad, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule